// File: doc/BRIEF.md
# Prioritized Interrupt Request and Service Tracker

This block keeps track of up to 256 interrupt vectors for one core. It holds three bitmaps of eight 32-bit words each: one for requests waiting to be taken, one for vectors the core is servicing, and one for the trigger type of each vector. The bit for vector v sits in word v>>5 at bit v&31. From a task priority value and the highest vector in service it derives a processor priority. A pending vector is offered to the core only when its priority class, the upper nibble, is above that priority.

Requests arrive on an accept port carrying a vector and a level/edge flag. The core takes the offered vector with an acknowledge strobe. It ends servicing with an end-of-interrupt strobe. An end-of-interrupt retires the highest vector in service and emits a one-cycle broadcast pulse with that vector and its trigger type. The pulse is held back when directed end-of-interrupt is enabled. Highest-vector searches are combinational priority encoders over the next-state bitmaps. Every output therefore shows the state produced by the clock edge that captured a strobe.

Top module: `irqtrk_core`

## Requirements
- R1: When enabled, an accept with vector >= 16 sets that vector's request bit. The offered vector is always the highest pending one (0xFF outranks 0x10).
- R2: An accepted vector whose request bit is already set raises acc_coalesced for one cycle, after the capturing edge. A first request does not raise it.
- R3: Accepts have no effect unless hw_en and sw_en are both 1, and intr_present stays 0 while either is 0.
- R4: Accepts of vectors 0 to 15 are ignored, and such a vector is never offered.
- R5: ppr equals the task priority when task_priority[7:4] >= top_in_service[7:4], else top_in_service with bits [3:0] cleared. With nothing in service the in-service value counts as 0.
- R6: intr_present is 1 only when {top_pending[7:4],4'h0} is strictly greater than ppr (all 8 bits compared).
- R7: An acknowledge while intr_present is 1 moves intr_vector from the pending to the in-service bitmap. ppr is recomputed.
- R8: An end-of-interrupt clears the highest in-service bit and recomputes ppr. On the next edge it raises eoi_bcast_valid for one cycle with that vector.
- R9: The trigger bit is set by a level accept (acc_level=1) and cleared by an edge accept. eoi_bcast_level reports it (1 level, 0 edge), and the end-of-interrupt clears it.
- R10: With eoi_direct_en=1 an end-of-interrupt still retires the vector but no broadcast pulse appears.
- R11: An end-of-interrupt with nothing in service changes nothing and emits no pulse.
- R12: After reset all bitmaps and the task priority are zero: intr_present, ppr, acc_coalesced and eoi_bcast_valid read 0.
- R13: A task priority write takes effect on ppr and intr_present at the capturing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_en | input | 1 | Hardware enable |
| sw_en | input | 1 | Software enable |
| eoi_direct_en | input | 1 | Suppress the end-of-interrupt broadcast |
| acc_valid | input | 1 | Accept strobe |
| acc_vector | input | 8 | Vector to accept |
| acc_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_wr | input | 1 | Task priority write strobe |
| tpr_wdata | input | 8 | Task priority value |
| intr_present | output | 1 | A vector is offered to the core |
| intr_vector | output | 8 | Offered vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast_valid | output | 1 | One-cycle end-of-interrupt broadcast |
| eoi_bcast_vector | output | 8 | Retired vector |
| eoi_bcast_level | output | 1 | Trigger type of the retired vector |
| acc_coalesced | output | 1 | Accept merged with an already pending request |

## Verification
A corrupted pending bitmap shows up on intr_vector, or as a missing intr_present, right after the edge that should have set or cleared the bit. A corrupted in-service bitmap is exposed through ppr at once, and later as a wrong vector on the broadcast pulse. A lost trigger bit shows only when that vector retires, as a wrong eoi_bcast_level. The directed tests therefore finish each acknowledge with an end-of-interrupt and check the pulse.

// File: rtl/irqtrk_pkg.sv
package irqtrk_pkg;
  // width of the sub-class field below the priority class
  localparam int unsigned SUB_W = 4;

  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irqtrk_find_top.sv
module irqtrk_find_top #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BIT_W = $clog2(WORD_W),
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned IDX_W = WSEL_W + BIT_W
) (
  input  logic [WORDS-1:0][WORD_W-1:0] bits,
  output logic                         found,
  output logic [IDX_W-1:0]             idx
);
  logic [WORDS-1:0]             word_any;
  logic [WORDS-1:0][BIT_W-1:0]  word_pos;
  logic [WSEL_W-1:0]            wsel;

  // per-word priority encoders
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_comb begin
      word_pos[w] = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (bits[w][b]) word_pos[w] = BIT_W'(b);
      end
    end
    assign word_any[w] = |bits[w];
  end

  // pick the highest non-empty word
  always_comb begin
    wsel = '0;
    for (int w = 0; w < WORDS; w++) begin
      if (word_any[w]) wsel = WSEL_W'(w);
    end
  end

  assign found = |word_any;
  assign idx   = found ? {wsel, word_pos[wsel]} : '0;
endmodule

// File: rtl/irqtrk_bitmap.sv
module irqtrk_bitmap #(
  parameter int unsigned WORDS  = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BIT_W = $clog2(WORD_W),
  localparam int unsigned IDX_W = $clog2(WORDS) + BIT_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_en,
  input  logic [IDX_W-1:0]             clr_idx,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic                         wr_val,
  output logic [WORDS-1:0][WORD_W-1:0] cur,
  output logic [WORDS-1:0][WORD_W-1:0] nxt
);
  // next state: clear first, then the write wins on the same bit
  always_comb begin
    nxt = cur;
    if (clr_en) nxt[clr_idx[IDX_W-1:BIT_W]][clr_idx[BIT_W-1:0]] = 1'b0;
    if (wr_en)  nxt[wr_idx[IDX_W-1:BIT_W]][wr_idx[BIT_W-1:0]]   = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cur <= '0;
    else if (clr_en || wr_en) cur <= nxt;
  end
endmodule

// File: rtl/irqtrk_prio.sv
module irqtrk_prio
  import irqtrk_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic [VEC_W-1:0] tpr,
  input  logic             isr_found,
  input  logic [VEC_W-1:0] isr_top,
  output logic [VEC_W-1:0] ppr
);
  logic [VEC_W-1:0] isr_val;

  always_comb begin
    isr_val = isr_found ? isr_top : '0;
    if (tpr[VEC_W-1:SUB_W] >= isr_val[VEC_W-1:SUB_W]) ppr = tpr;
    else ppr = {isr_val[VEC_W-1:SUB_W], {SUB_W{1'b0}}};
  end
endmodule

// File: rtl/irqtrk_core.sv
module irqtrk_core
  import irqtrk_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned MIN_VEC = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_en,
  input  logic       sw_en,
  input  logic       eoi_direct_en,
  input  logic       acc_valid,
  input  logic [7:0] acc_vector,
  input  logic       acc_level,
  input  logic       ack,
  input  logic       eoi,
  input  logic       tpr_wr,
  input  logic [7:0] tpr_wdata,
  output logic       intr_present,
  output logic [7:0] intr_vector,
  output logic [7:0] ppr,
  output logic       eoi_bcast_valid,
  output logic [7:0] eoi_bcast_vector,
  output logic       eoi_bcast_level,
  output logic       acc_coalesced
);
  localparam int unsigned VEC_W = $clog2(NUM_VEC);
  localparam int unsigned WORDS = NUM_VEC / WORD_W;
  localparam int unsigned BIT_W = $clog2(WORD_W);

  typedef logic [WORDS-1:0][WORD_W-1:0] map_t;

  map_t irr_q, irr_d, isr_q, isr_d, tmr_q, tmr_d;

  logic             en, acc_ok, ack_ok, eoi_ok, coal_hit, eoi_lvl;
  logic             irr_found_d, isr_found_d, present_d;
  logic [VEC_W-1:0] irr_top_d, isr_top_d, ppr_d, tpr_d, acc_v;

  // registered state
  logic             present_q, isr_found_q, coal_q, eoi_v_q, eoi_lvl_q;
  logic [VEC_W-1:0] vec_q, isr_top_q, ppr_q, tpr_q, eoi_vec_q;

  // ---------------- strobes qualified ----------------
  assign acc_v  = acc_vector[VEC_W-1:0];
  assign en     = hw_en & sw_en;
  assign acc_ok = acc_valid & en & (acc_vector >= 8'(MIN_VEC));
  assign ack_ok = ack & present_q;
  assign eoi_ok = eoi & isr_found_q;

  // ---------------- bitmaps ----------------
  irqtrk_bitmap #(.WORDS(WORDS), .WORD_W(WORD_W)) u_irr (
    .clk, .rst_n,
    .clr_en (ack_ok), .clr_idx(vec_q),
    .wr_en  (acc_ok), .wr_idx (acc_v), .wr_val(1'b1),
    .cur    (irr_q),  .nxt    (irr_d)
  );

  irqtrk_bitmap #(.WORDS(WORDS), .WORD_W(WORD_W)) u_isr (
    .clk, .rst_n,
    .clr_en (eoi_ok), .clr_idx(isr_top_q),
    .wr_en  (ack_ok), .wr_idx (vec_q), .wr_val(1'b1),
    .cur    (isr_q),  .nxt    (isr_d)
  );

  irqtrk_bitmap #(.WORDS(WORDS), .WORD_W(WORD_W)) u_tmr (
    .clk, .rst_n,
    .clr_en (eoi_ok), .clr_idx(isr_top_q),
    .wr_en  (acc_ok), .wr_idx (acc_v), .wr_val(acc_level),
    .cur    (tmr_q),  .nxt    (tmr_d)
  );

  assign coal_hit = irr_q[acc_v[VEC_W-1:BIT_W]][acc_v[BIT_W-1:0]];
  assign eoi_lvl  = tmr_q[isr_top_q[VEC_W-1:BIT_W]][isr_top_q[BIT_W-1:0]];

  // ---------------- searches on next state ----------------
  irqtrk_find_top #(.WORDS(WORDS), .WORD_W(WORD_W)) u_irr_top (
    .bits(irr_d), .found(irr_found_d), .idx(irr_top_d)
  );

  irqtrk_find_top #(.WORDS(WORDS), .WORD_W(WORD_W)) u_isr_top (
    .bits(isr_d), .found(isr_found_d), .idx(isr_top_d)
  );

  assign tpr_d = tpr_wr ? tpr_wdata[VEC_W-1:0] : tpr_q;

  irqtrk_prio #(.VEC_W(VEC_W)) u_prio (
    .tpr(tpr_d), .isr_found(isr_found_d), .isr_top(isr_top_d), .ppr(ppr_d)
  );

  assign present_d = en & irr_found_d &
                     ({irr_top_d[VEC_W-1:SUB_W], {SUB_W{1'b0}}} > ppr_d);

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present_q   <= 1'b0;
      vec_q       <= '0;
      isr_found_q <= 1'b0;
      isr_top_q   <= '0;
      ppr_q       <= '0;
      coal_q      <= 1'b0;
      eoi_v_q     <= 1'b0;
    end else begin
      present_q   <= present_d;
      vec_q       <= irr_top_d;
      isr_found_q <= isr_found_d;
      isr_top_q   <= isr_top_d;
      ppr_q       <= ppr_d;
      coal_q      <= acc_ok & coal_hit;
      eoi_v_q     <= eoi_ok & ~eoi_direct_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tpr_q <= '0;
    else if (tpr_wr) tpr_q <= tpr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoi_vec_q <= '0;
      eoi_lvl_q <= 1'b0;
    end else if (eoi_ok) begin
      eoi_vec_q <= isr_top_q;
      eoi_lvl_q <= eoi_lvl;
    end
  end

  // ---------------- outputs ----------------
  assign intr_present     = present_q;
  assign intr_vector      = 8'(vec_q);
  assign ppr              = 8'(ppr_q);
  assign acc_coalesced    = coal_q;
  assign eoi_bcast_valid  = eoi_v_q;
  assign eoi_bcast_vector = 8'(eoi_vec_q);
  assign eoi_bcast_level  = eoi_lvl_q;
endmodule

// File: rtl/irqtrk_chk.sv
module irqtrk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_en,
  input logic       sw_en,
  input logic       eoi_direct_en,
  input logic       acc_valid,
  input logic       eoi,
  input logic       intr_present,
  input logic [7:0] intr_vector,
  input logic [7:0] ppr,
  input logic       eoi_bcast_valid,
  input logic       acc_coalesced
);
  // R6: an offered vector's class is strictly above ppr
  a_r6_class_above: assert property (@(posedge clk) disable iff (!rst_n)
    intr_present |-> ({intr_vector[7:4], 4'h0} > ppr));

  // R3: nothing is offered after a cycle with an enable low
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_en && sw_en) |=> !intr_present);

  // R3: a disabled accept never reports coalescing
  a_r3_no_coal_off: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(hw_en && sw_en)) |=> !acc_coalesced);

  // R4: offered vectors are never below 16
  a_r4_low_never: assert property (@(posedge clk) disable iff (!rst_n)
    intr_present |-> (intr_vector >= 8'd16));

  // R8: a broadcast pulse follows an end-of-interrupt strobe
  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoi_bcast_valid) |-> $past(eoi));

  // R10: directed mode suppresses the broadcast
  a_r10_directed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && eoi_direct_en) |=> !eoi_bcast_valid);

  // R2: coalescing only follows an accept
  a_r2_coal_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_coalesced) |-> $past(acc_valid));
endmodule

bind irqtrk_core irqtrk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en(sw_en),
  .eoi_direct_en(eoi_direct_en), .acc_valid(acc_valid), .eoi(eoi),
  .intr_present(intr_present), .intr_vector(intr_vector), .ppr(ppr),
  .eoi_bcast_valid(eoi_bcast_valid), .acc_coalesced(acc_coalesced)
);

// File: tb/tb_irqtrk_core.sv
module tb_irqtrk_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n, hw_en, sw_en, eoi_direct_en;
  logic       acc_valid, acc_level, ack, eoi, tpr_wr;
  logic [7:0] acc_vector, tpr_wdata;
  logic       intr_present, eoi_bcast_valid, eoi_bcast_level, acc_coalesced;
  logic [7:0] intr_vector, ppr, eoi_bcast_vector;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqtrk_core dut (
    .clk, .rst_n, .hw_en, .sw_en, .eoi_direct_en,
    .acc_valid, .acc_vector, .acc_level, .ack, .eoi, .tpr_wr, .tpr_wdata,
    .intr_present, .intr_vector, .ppr,
    .eoi_bcast_valid, .eoi_bcast_vector, .eoi_bcast_level, .acc_coalesced
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // each helper drives at a falling edge and returns at the next falling edge
  task automatic do_acc(input logic [7:0] v, input logic lvl);
    @(negedge clk); acc_valid = 1'b1; acc_vector = v; acc_level = lvl;
    @(negedge clk); acc_valid = 1'b0;
  endtask
  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask
  task automatic do_eoi();
    @(negedge clk); eoi = 1'b1;
    @(negedge clk); eoi = 1'b0;
  endtask
  task automatic do_tpr(input logic [7:0] t);
    @(negedge clk); tpr_wr = 1'b1; tpr_wdata = t;
    @(negedge clk); tpr_wr = 1'b0;
  endtask
  task automatic offered(input string tag, input logic p, input logic [7:0] v);
    chk({tag, " present"}, 32'(intr_present), 32'(p));
    if (p) chk({tag, " vector"}, 32'(intr_vector), 32'(v));
  endtask

  task automatic t_reset();
    chk("R12 present", 32'(intr_present), 0);
    chk("R12 ppr", 32'(ppr), 0);
    chk("R12 bcast", 32'(eoi_bcast_valid), 0);
    chk("R12 coal", 32'(acc_coalesced), 0);
  endtask

  task automatic t_accept();
    do_acc(8'h31, 1'b0);
    chk("R2 first no coal", 32'(acc_coalesced), 0);
    offered("R1 0x31", 1'b1, 8'h31);
    do_acc(8'h85, 1'b0);
    offered("R1 highest 0x85", 1'b1, 8'h85);
    do_acc(8'h85, 1'b0);
    chk("R2 coalesced", 32'(acc_coalesced), 1);
  endtask

  task automatic t_ack_eoi();
    do_ack();
    chk("R7 ppr after ack", 32'(ppr), 32'h80);
    offered("R7 masked by isr", 1'b0, 8'h00);
    do_eoi();
    chk("R8 bcast valid", 32'(eoi_bcast_valid), 1);
    chk("R8 bcast vector", 32'(eoi_bcast_vector), 32'h85);
    chk("R9 bcast edge", 32'(eoi_bcast_level), 0);
    chk("R8 ppr restored", 32'(ppr), 0);
    offered("R8 next offered", 1'b1, 8'h31);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(eoi_bcast_valid), 0);
  endtask

  task automatic t_level();
    do_acc(8'h40, 1'b1);
    offered("R1 0x40", 1'b1, 8'h40);
    do_ack();
    chk("R5 ppr 0x40", 32'(ppr), 32'h40);
    do_eoi();
    chk("R9 level", 32'(eoi_bcast_level), 1);
    chk("R8 vector 0x40", 32'(eoi_bcast_vector), 32'h40);
    do_acc(8'h40, 1'b0);
    do_ack();
    do_eoi();
    chk("R9 edge after relevel", 32'(eoi_bcast_level), 0);
    offered("R9 back to 0x31", 1'b1, 8'h31);
  endtask

  task automatic t_tpr();
    do_tpr(8'h45);
    chk("R13 ppr tpr", 32'(ppr), 32'h45);
    offered("R13 masked", 1'b0, 8'h00);
    do_acc(8'h4F, 1'b0);
    offered("R6 equal class not shown", 1'b0, 8'h00);
    do_acc(8'h50, 1'b0);
    offered("R6 above shown", 1'b1, 8'h50);
    do_ack();
    chk("R5 isr class wins", 32'(ppr), 32'h50);
    do_tpr(8'h5A);
    chk("R5 tpr equal class wins", 32'(ppr), 32'h5A);
    do_eoi();
    chk("R8 vector 0x50", 32'(eoi_bcast_vector), 32'h50);
    chk("R5 tpr only", 32'(ppr), 32'h5A);
    offered("R6 still masked", 1'b0, 8'h00);
    do_tpr(8'h00);
    offered("R13 unmasked", 1'b1, 8'h4F);
  endtask

  task automatic t_eoi_empty();
    do_eoi();
    chk("R11 no pulse", 32'(eoi_bcast_valid), 0);
    chk("R11 ppr", 32'(ppr), 0);
    offered("R11 unchanged", 1'b1, 8'h4F);
  endtask

  task automatic t_disable();
    @(negedge clk); sw_en = 1'b0;
    @(negedge clk);
    offered("R3 sw off hides", 1'b0, 8'h00);
    do_acc(8'h90, 1'b0);
    chk("R3 no coal", 32'(acc_coalesced), 0);
    @(negedge clk); sw_en = 1'b1; hw_en = 1'b0;
    do_acc(8'hA0, 1'b0);
    offered("R3 hw off hides", 1'b0, 8'h00);
    @(negedge clk); hw_en = 1'b1;
    @(negedge clk);
    offered("R3 ignored accepts", 1'b1, 8'h4F);
  endtask

  task automatic t_directed();
    @(negedge clk); eoi_direct_en = 1'b1;
    do_ack();
    chk("R10 ppr 0x40", 32'(ppr), 32'h40);
    do_eoi();
    chk("R10 no pulse", 32'(eoi_bcast_valid), 0);
    chk("R10 retired", 32'(ppr), 0);
    offered("R10 next", 1'b1, 8'h31);
    @(negedge clk); eoi_direct_en = 1'b0;
  endtask

  task automatic t_bounds();
    do_ack();
    chk("R7 ppr 0x30", 32'(ppr), 32'h30);
    do_eoi();
    chk("R8 vector 0x31", 32'(eoi_bcast_vector), 32'h31);
    offered("R7 empty", 1'b0, 8'h00);
    do_acc(8'h0A, 1'b0);
    offered("R4 low ignored", 1'b0, 8'h00);
    do_acc(8'h0A, 1'b0);
    chk("R4 low no coal", 32'(acc_coalesced), 0);
    do_acc(8'hFF, 1'b0);
    offered("R1 top 0xFF", 1'b1, 8'hFF);
    do_acc(8'h10, 1'b0);
    offered("R1 0xFF over 0x10", 1'b1, 8'hFF);
    do_ack();
    chk("R5 ppr 0xF0", 32'(ppr), 32'hF0);
    offered("R6 0x10 masked", 1'b0, 8'h00);
    do_eoi();
    chk("R8 vector 0xFF", 32'(eoi_bcast_vector), 32'hFF);
    offered("R1 lowest 0x10", 1'b1, 8'h10);
  endtask

  initial begin
    rst_n = 1'b0; hw_en = 1'b1; sw_en = 1'b1; eoi_direct_en = 1'b0;
    acc_valid = 1'b0; acc_vector = '0; acc_level = 1'b0;
    ack = 1'b0; eoi = 1'b0; tpr_wr = 1'b0; tpr_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_accept();
    t_ack_eoi();
    t_level();
    t_tpr();
    t_eoi_empty();
    t_disable();
    t_directed();
    t_bounds();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule